// File: doc/BRIEF.md
# Instruction Step Sequencer

This block runs one instruction step of a 64-bit core with optional 16-bit compressed encodings. A pulse on `step_go` starts a step. The block first looks for an interrupt that is both pending and enabled. If it finds one, it takes the interrupt path and issues no fetch. Otherwise it fetches one 32-bit word at the current program counter and works out the instruction length from the two lowest bits of that word. It then produces either the address of the next instruction or a trap request that carries a cause and an info value.

Each step ends in a single commit cycle. In that cycle `step_done` is high and the result ports are valid, and the block's program counter takes the value shown on `next_pc`. Steps that trap or take an interrupt also end this way. Decoding beyond the length, execution, the control-register file and the computation of the handler address are outside the block. The handler address comes in as an input. The fetch port is a valid/ready request channel with one request in flight at a time. The response is accepted in any cycle after the request handshake.

Top module: `insn_step_seq`

## Requirements
- R1: At the start of a step, an interrupt is taken when `irq_pending & irq_enable` is nonzero. An interrupt step issues no fetch request. It commits with `irq_valid` high and `trap_cause` equal to the highest set index of `irq_pending & irq_enable`. `irq_to_lower` equals `irq_deleg` at that index. Pending lines that are masked by `irq_enable` are ignored, and a fetch follows.
- R2: A step with no interrupt issues exactly one fetch request, with `fetch_addr` equal to `pc`. `fetch_req_valid` and `fetch_addr` stay unchanged until `fetch_req_ready` is seen, even when `pc` is not 4-byte aligned.
- R3: A fetched word with bits [1:0] equal to 2'b11 has length 4 (`insn_size` = 4). Any other value of bits [1:0] gives length 2.
- R4: `insn` reports a 4-byte instruction as the whole 32-bit word, zero-extended to 64 bits. It reports a 2-byte instruction as bits [15:0] of the word, zero-extended.
- R5: A 2-byte instruction fetched while `cmp_en` is 0 commits with `trap_valid` high, cause 2 and `trap_info` equal to bits [15:0] of the word, zero-extended. `next_pc` is then `handler_pc`, not `pc` + 2.
- R6: A legal instruction commits with `next_pc` equal to `pc` + `insn_size`, and with `trap_valid` and `irq_valid` low.
- R7: A fetch response with `fetch_rsp_fault` high commits with `trap_valid` high, `trap_cause` equal to `fetch_rsp_cause`, `trap_info` equal to the PC of the fetch and `next_pc` equal to `handler_pc`. The fault takes precedence over the length check.
- R8: At the end of every commit cycle, `pc` takes the committed `next_pc` value. This holds for traps and interrupts too.
- R9: `step_done`, `trap_valid` and `irq_valid` are each high for exactly one cycle per step. `trap_valid` and `irq_valid` are never high together.
- R10: After reset, `pc` equals `RESET_PC`, and `fetch_req_valid`, `step_done`, `trap_valid` and `irq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_go | input | 1 | Starts one step when the block is idle |
| cmp_en | input | 1 | Compressed encodings allowed |
| irq_pending | input | NIRQ | Pending interrupt lines |
| irq_enable | input | NIRQ | Interrupt enables |
| irq_deleg | input | NIRQ | Per-line delegation to a lower privilege level |
| handler_pc | input | XLEN | Target address for traps and interrupts |
| fetch_req_valid | output | 1 | Fetch request valid |
| fetch_req_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | XLEN | Fetch address |
| fetch_rsp_valid | input | 1 | Fetch response valid |
| fetch_rsp_data | input | 32 | Fetched word |
| fetch_rsp_fault | input | 1 | Fetch faulted |
| fetch_rsp_cause | input | CAUSE_W | Cause code of a fetch fault |
| step_done | output | 1 | Commit cycle of a step |
| insn | output | XLEN | Committed instruction bits, zero-extended |
| insn_size | output | 3 | Instruction length in bytes (0 on trap or interrupt) |
| next_pc | output | XLEN | Address the step continues at |
| pc | output | XLEN | Architectural program counter |
| trap_valid | output | 1 | Synchronous trap request |
| irq_valid | output | 1 | Interrupt taken |
| irq_to_lower | output | 1 | Taken interrupt is delegated |
| trap_cause | output | CAUSE_W | Trap or interrupt cause |
| trap_info | output | XLEN | Trap info value |

## Verification
Fetched words are tried with each value of bits [1:0], both with compressed support on and with it off. This separates the length rule from the illegal-compressed rule and shows which bits end up in `insn` and `trap_info`. A faulting fetch with compressed support off shows that the fault takes precedence. Overlapping pending lines separate the priority choice from the delegation lookup, and pending lines that are masked show that the enable gate is honoured. Back-to-back steps move the PC to a 2-byte boundary and then to the handler, so the fetch address and the commit update are tested at unaligned and redirected values. A stalled `fetch_req_ready` shows that the request is held.

// File: rtl/step_pkg.sv
package step_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK_INT,
    ST_FETCH_WAIT,
    ST_DECODE_LEN,
    ST_COMMIT
  } step_state_e;

  // A word whose two low bits are both set holds a full-width instruction.
  function automatic logic is_full_width(input logic [31:0] w);
    return (w[1:0] == 2'b11);
  endfunction

  // Instruction length in bytes as chosen from the low bits.
  function automatic logic [2:0] insn_bytes(input logic [31:0] w);
    return is_full_width(w) ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NIRQ  = 4,
  parameter int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic [NIRQ-1:0]  pend,
  input  logic [NIRQ-1:0]  en,
  input  logic [NIRQ-1:0]  deleg,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic             to_lower
);
  logic [NIRQ-1:0] live;
  // hit[i] marks line i as the winner: live and no higher line live.
  logic [NIRQ-1:0] hit;
  logic [NIRQ:0]   higher_live;

  assign live = pend & en;
  assign higher_live[NIRQ] = 1'b0;

  genvar g;
  generate
    for (g = NIRQ - 1; g >= 0; g--) begin : g_chain
      assign hit[g]         = live[g] & ~higher_live[g+1];
      assign higher_live[g] = higher_live[g+1] | live[g];
    end
  endgenerate

  always_comb begin
    idx      = '0;
    to_lower = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      if (hit[i]) begin
        idx      = IDX_W'(i);
        to_lower = deleg[i];
      end
    end
  end

  assign any = higher_live[0];

endmodule

// File: rtl/len_decode.sv
module len_decode
  import step_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int CAUSE_W   = 4,
  parameter int ILL_CAUSE = 2
) (
  input  logic [31:0]        word,
  input  logic               fault,
  input  logic [CAUSE_W-1:0] fault_cause,
  input  logic               cmp_en,
  input  logic [XLEN-1:0]    pc,
  output logic               trap,
  output logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    info,
  output logic [XLEN-1:0]    insn,
  output logic [2:0]         size
);
  logic full;

  always_comb begin
    full  = is_full_width(word);
    insn  = full ? XLEN'(word) : XLEN'(word[15:0]);
    size  = insn_bytes(word);
    trap  = 1'b0;
    cause = '0;
    info  = '0;
    if (fault) begin
      trap  = 1'b1;
      cause = fault_cause;
      info  = pc;
      insn  = '0;
      size  = 3'd0;
    end else if (!full && !cmp_en) begin
      trap  = 1'b1;
      cause = CAUSE_W'(ILL_CAUSE);
      info  = insn;
      size  = 3'd0;
    end
  end

endmodule

// File: rtl/insn_step_seq.sv
module insn_step_seq
  import step_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          NIRQ      = 4,
  parameter int          CAUSE_W   = 4,
  parameter int          ILL_CAUSE = 2,
  parameter logic [63:0] RESET_PC  = 64'h0000_0000_8000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_go,
  input  logic               cmp_en,
  input  logic [NIRQ-1:0]    irq_pending,
  input  logic [NIRQ-1:0]    irq_enable,
  input  logic [NIRQ-1:0]    irq_deleg,
  input  logic [XLEN-1:0]    handler_pc,
  output logic               fetch_req_valid,
  input  logic               fetch_req_ready,
  output logic [XLEN-1:0]    fetch_addr,
  input  logic               fetch_rsp_valid,
  input  logic [31:0]        fetch_rsp_data,
  input  logic               fetch_rsp_fault,
  input  logic [CAUSE_W-1:0] fetch_rsp_cause,
  output logic               step_done,
  output logic [XLEN-1:0]    insn,
  output logic [2:0]         insn_size,
  output logic [XLEN-1:0]    next_pc,
  output logic [XLEN-1:0]    pc,
  output logic               trap_valid,
  output logic               irq_valid,
  output logic               irq_to_lower,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_info
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  function automatic logic [XLEN-1:0] advance_pc(input logic [XLEN-1:0] p,
                                                 input logic [2:0]      n);
    return p + XLEN'(n);
  endfunction

  step_state_e        state_q;
  logic               req_sent_q;
  logic [XLEN-1:0]    pc_q;
  logic [31:0]        word_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] fcause_q;

  logic               r_trap, r_irq, r_lower;
  logic [CAUSE_W-1:0] r_cause;
  logic [XLEN-1:0]    r_info, r_insn, r_npc;
  logic [2:0]         r_size;

  // Named events, exposed for the checker.
  logic               ev_irq_take;
  logic               ev_fetch_fire;
  logic               ev_rsp_take;

  logic               irq_any;
  logic [IDX_W-1:0]   irq_idx;
  logic               irq_lower;

  logic               d_trap;
  logic [CAUSE_W-1:0] d_cause;
  logic [XLEN-1:0]    d_info, d_insn;
  logic [2:0]         d_size;

  irq_pick #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_irq (
    .pend     (irq_pending),
    .en       (irq_enable),
    .deleg    (irq_deleg),
    .any      (irq_any),
    .idx      (irq_idx),
    .to_lower (irq_lower)
  );

  len_decode #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .ILL_CAUSE(ILL_CAUSE)) u_len (
    .word        (word_q),
    .fault       (fault_q),
    .fault_cause (fcause_q),
    .cmp_en      (cmp_en),
    .pc          (pc_q),
    .trap        (d_trap),
    .cause       (d_cause),
    .info        (d_info),
    .insn        (d_insn),
    .size        (d_size)
  );

  assign fetch_req_valid = (state_q == ST_FETCH_WAIT) && !req_sent_q;
  assign fetch_addr      = pc_q;
  assign ev_irq_take     = (state_q == ST_CHECK_INT) && irq_any;
  assign ev_fetch_fire   = fetch_req_valid && fetch_req_ready;
  assign ev_rsp_take     = (state_q == ST_FETCH_WAIT) && req_sent_q && fetch_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      req_sent_q <= 1'b0;
      pc_q       <= RESET_PC[XLEN-1:0];
      word_q     <= '0;
      fault_q    <= 1'b0;
      fcause_q   <= '0;
      r_trap     <= 1'b0;
      r_irq      <= 1'b0;
      r_lower    <= 1'b0;
      r_cause    <= '0;
      r_info     <= '0;
      r_insn     <= '0;
      r_npc      <= RESET_PC[XLEN-1:0];
      r_size     <= 3'd0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (step_go) state_q <= ST_CHECK_INT;
        end
        ST_CHECK_INT: begin
          if (irq_any) begin
            r_irq   <= 1'b1;
            r_trap  <= 1'b0;
            r_lower <= irq_lower;
            r_cause <= CAUSE_W'(irq_idx);
            r_info  <= '0;
            r_insn  <= '0;
            r_size  <= 3'd0;
            r_npc   <= handler_pc;
            state_q <= ST_COMMIT;
          end else begin
            req_sent_q <= 1'b0;
            state_q    <= ST_FETCH_WAIT;
          end
        end
        ST_FETCH_WAIT: begin
          if (ev_fetch_fire) req_sent_q <= 1'b1;
          if (ev_rsp_take) begin
            word_q   <= fetch_rsp_data;
            fault_q  <= fetch_rsp_fault;
            fcause_q <= fetch_rsp_cause;
            state_q  <= ST_DECODE_LEN;
          end
        end
        ST_DECODE_LEN: begin
          r_irq   <= 1'b0;
          r_lower <= 1'b0;
          r_trap  <= d_trap;
          r_cause <= d_cause;
          r_info  <= d_info;
          r_insn  <= d_insn;
          r_size  <= d_size;
          r_npc   <= d_trap ? handler_pc : advance_pc(pc_q, d_size);
          state_q <= ST_COMMIT;
        end
        ST_COMMIT: begin
          pc_q    <= r_npc;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_done    = (state_q == ST_COMMIT);
  assign trap_valid   = step_done && r_trap;
  assign irq_valid    = step_done && r_irq;
  assign irq_to_lower = r_lower;
  assign trap_cause   = r_cause;
  assign trap_info    = r_info;
  assign insn         = r_insn;
  assign insn_size    = r_size;
  assign next_pc      = r_npc;
  assign pc           = pc_q;

endmodule

// File: rtl/insn_step_seq_chk.sv
module insn_step_seq_chk #(
  parameter int XLEN      = 64,
  parameter int CAUSE_W   = 4,
  parameter int ILL_CAUSE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_req_valid,
  input logic               fetch_req_ready,
  input logic [XLEN-1:0]    fetch_addr,
  input logic [XLEN-1:0]    pc,
  input logic               step_done,
  input logic               trap_valid,
  input logic               irq_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [XLEN-1:0]    next_pc,
  input logic [XLEN-1:0]    handler_pc,
  input logic [2:0]         insn_size,
  input logic               ev_irq_take
);

  AST_IRQ_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_take |=> (!fetch_req_valid && irq_valid)); // R1

  AST_REQ_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_valid |-> (fetch_addr == pc)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_valid && !fetch_req_ready) |=> (fetch_req_valid && $stable(fetch_addr))); // R2

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !trap_valid && !irq_valid) |-> (insn_size == 3'd2 || insn_size == 3'd4)); // R3

  AST_ILL_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == CAUSE_W'(ILL_CAUSE)) |-> (next_pc == handler_pc)); // R5

  AST_LEGAL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !trap_valid && !irq_valid) |-> (next_pc == pc + XLEN'(insn_size))); // R6

  AST_PC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> (pc == $past(next_pc))); // R8

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> !trap_valid); // R9

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R9

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_valid && irq_valid)); // R9

endmodule

bind insn_step_seq insn_step_seq_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ILL_CAUSE(ILL_CAUSE)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_req_valid (fetch_req_valid),
  .fetch_req_ready (fetch_req_ready),
  .fetch_addr      (fetch_addr),
  .pc              (pc),
  .step_done       (step_done),
  .trap_valid      (trap_valid),
  .irq_valid       (irq_valid),
  .trap_cause      (trap_cause),
  .next_pc         (next_pc),
  .handler_pc      (handler_pc),
  .insn_size       (insn_size),
  .ev_irq_take     (ev_irq_take)
);

// File: tb/sim_insn_step_seq.sv
module sim_insn_step_seq;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] RST_PC     = 64'h0000_0000_8000_0000;
  localparam logic [63:0] HANDLER    = 64'h0000_0000_0000_1000;
  localparam logic [3:0]  FCAUSE     = 4'd1;
  localparam logic [3:0]  DELEG      = 4'b0100;
  localparam int          NVEC       = 9;

  // {pend[3:0], cmp_en, fault, word[31:0], exp_trap, exp_irq, exp_size[2:0], exp_cause[3:0]}
  localparam logic [46:0] VEC [NVEC] = '{
    {4'b0000, 1'b1, 1'b0, 32'h00A0_0093, 1'b0, 1'b0, 3'd4, 4'd0}, // R3 full width
    {4'b0000, 1'b1, 1'b0, 32'hDEAD_4501, 1'b0, 1'b0, 3'd2, 4'd0}, // R3 low 01
    {4'b0000, 1'b0, 1'b0, 32'h1234_8082, 1'b1, 1'b0, 3'd0, 4'd2}, // R5 illegal 16-bit
    {4'b0000, 1'b0, 1'b0, 32'hFFFF_0013, 1'b0, 1'b0, 3'd4, 4'd0}, // R3 32-bit with cmp off
    {4'b0000, 1'b1, 1'b0, 32'h5555_0000, 1'b0, 1'b0, 3'd2, 4'd0}, // R3 low 00
    {4'b0000, 1'b1, 1'b1, 32'h0000_0013, 1'b1, 1'b0, 3'd0, 4'd1}, // R7 fault
    {4'b0110, 1'b1, 1'b0, 32'h0000_0013, 1'b0, 1'b1, 3'd0, 4'd2}, // R1 two lines
    {4'b0001, 1'b1, 1'b0, 32'h0000_0013, 1'b0, 1'b1, 3'd0, 4'd0}, // R1 line 0
    {4'b0000, 1'b0, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 3'd0, 4'd1}  // R7 fault over illegal
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_go = 1'b0;
  logic        cmp_en = 1'b1;
  logic [3:0]  irq_pending = '0;
  logic [3:0]  irq_enable = 4'hF;
  logic [3:0]  irq_deleg = DELEG;
  logic [63:0] handler_pc = HANDLER;
  logic        fetch_req_valid;
  logic        fetch_req_ready = 1'b0;
  logic [63:0] fetch_addr;
  logic        fetch_rsp_valid = 1'b0;
  logic [31:0] fetch_rsp_data = '0;
  logic        fetch_rsp_fault = 1'b0;
  logic [3:0]  fetch_rsp_cause = FCAUSE;
  logic        step_done;
  logic [63:0] insn;
  logic [2:0]  insn_size;
  logic [63:0] next_pc;
  logic [63:0] pc;
  logic        trap_valid, irq_valid, irq_to_lower;
  logic [3:0]  trap_cause;
  logic [63:0] trap_info;

  insn_step_seq u0 (
    .clk(clk), .rst_n(rst_n), .step_go(step_go), .cmp_en(cmp_en),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_deleg(irq_deleg),
    .handler_pc(handler_pc),
    .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
    .fetch_addr(fetch_addr), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_data(fetch_rsp_data), .fetch_rsp_fault(fetch_rsp_fault),
    .fetch_rsp_cause(fetch_rsp_cause), .step_done(step_done), .insn(insn),
    .insn_size(insn_size), .next_pc(next_pc), .pc(pc), .trap_valid(trap_valid),
    .irq_valid(irq_valid), .irq_to_lower(irq_to_lower), .trap_cause(trap_cause),
    .trap_info(trap_info)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [63:0] pc_m;

  // Results of the last step.
  logic        got;
  int          fetches;
  logic        hold_ok;
  logic [63:0] f_addr;
  logic        o_trap, o_irq, o_lower, o_done_cnt_ok;
  logic [2:0]  o_size;
  logic [3:0]  o_cause;
  logic [63:0] o_info, o_insn, o_npc, pc_after;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_step(input logic [3:0] pend, input logic [3:0] en,
                          input logic cmp, input logic flt, input logic [31:0] word,
                          input int stall);
    int rsp_phase = 0;
    int st = stall;
    logic [63:0] held = '0;
    logic seen = 1'b0;
    got = 1'b0; fetches = 0; hold_ok = 1'b1; f_addr = '0;
    o_done_cnt_ok = 1'b1;
    @(negedge clk);
    irq_pending = pend; irq_enable = en; cmp_en = cmp;
    fetch_rsp_fault = flt; fetch_rsp_data = word;
    step_go = 1'b1;
    @(negedge clk);
    step_go = 1'b0;
    for (int c = 0; c < 60 && !got; c++) begin
      if (rsp_phase == 1) begin
        fetch_rsp_valid = 1'b1;
        rsp_phase = 2;
      end else begin
        fetch_rsp_valid = 1'b0;
      end
      if (step_done) begin
        got = 1'b1;
        o_trap = trap_valid; o_irq = irq_valid; o_lower = irq_to_lower;
        o_size = insn_size; o_cause = trap_cause; o_info = trap_info;
        o_insn = insn; o_npc = next_pc;
      end else if (fetch_req_valid) begin
        if (seen && fetch_addr != held) hold_ok = 1'b0;
        held = fetch_addr; seen = 1'b1;
        if (st > 0) begin
          fetch_req_ready = 1'b0;
          st--;
        end else begin
          fetch_req_ready = 1'b1;
          fetches++;
          f_addr = fetch_addr;
          rsp_phase = 1;
        end
      end else begin
        fetch_req_ready = 1'b0;
      end
      @(negedge clk);
    end
    fetch_rsp_valid = 1'b0;
    fetch_req_ready = 1'b0;
    // one negedge after the commit cycle
    if (step_done || trap_valid || irq_valid) o_done_cnt_ok = 1'b0;
    pc_after = pc;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(pc == RST_PC, "R10 reset pc", pc, RST_PC);
    check(!fetch_req_valid && !step_done && !trap_valid && !irq_valid,
          "R10 reset outputs quiet",
          {60'd0, fetch_req_valid, step_done, trap_valid, irq_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc == RST_PC && !fetch_req_valid, "R10 idle after reset", pc, RST_PC);
    pc_m = RST_PC;

    // Table of vectors.
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  v_pend  = VEC[i][46:43];
      logic        v_cmp   = VEC[i][42];
      logic        v_flt   = VEC[i][41];
      logic [31:0] v_word  = VEC[i][40:9];
      logic        e_trap  = VEC[i][8];
      logic        e_irq   = VEC[i][7];
      logic [2:0]  e_size  = VEC[i][6:4];
      logic [3:0]  e_cause = VEC[i][3:0];
      logic [63:0] e_npc;
      run_step(v_pend, 4'hF, v_cmp, v_flt, v_word, 0);
      check(got, "R9 step commits", {63'd0, got}, 64'd1);
      check(o_done_cnt_ok, "R9 flags drop after one cycle", {63'd0, o_done_cnt_ok}, 64'd1);
      check(o_trap == e_trap, "R5 R7 trap flag", {63'd0, o_trap}, {63'd0, e_trap});
      check(o_irq == e_irq, "R1 irq flag", {63'd0, o_irq}, {63'd0, e_irq});
      if (e_irq) begin
        check(fetches == 0, "R1 no fetch on interrupt", 64'(fetches), 64'd0);
        check(o_cause == e_cause, "R1 irq cause", {60'd0, o_cause}, {60'd0, e_cause});
        check(o_lower == DELEG[e_cause[1:0]], "R1 delegation",
              {63'd0, o_lower}, {63'd0, DELEG[e_cause[1:0]]});
        e_npc = HANDLER;
      end else begin
        check(fetches == 1, "R2 single fetch", 64'(fetches), 64'd1);
        check(f_addr == pc_m, "R2 fetch at pc", f_addr, pc_m);
        if (e_trap) begin
          check(o_cause == e_cause, "R5 R7 trap cause", {60'd0, o_cause}, {60'd0, e_cause});
          if (v_flt)
            check(o_info == pc_m, "R7 info is faulting pc", o_info, pc_m);
          else
            check(o_info == {48'd0, v_word[15:0]}, "R5 info is insn bits",
                  o_info, {48'd0, v_word[15:0]});
          e_npc = HANDLER;
        end else begin
          check(o_size == e_size, "R3 size", {61'd0, o_size}, {61'd0, e_size});
          if (e_size == 3'd4)
            check(o_insn == {32'd0, v_word}, "R4 full insn", o_insn, {32'd0, v_word});
          else
            check(o_insn == {48'd0, v_word[15:0]}, "R4 compressed insn",
                  o_insn, {48'd0, v_word[15:0]});
          e_npc = pc_m + 64'(e_size);
        end
      end
      check(o_npc == e_npc, "R5 R6 next pc", o_npc, e_npc);
      check(pc_after == e_npc, "R8 pc updated", pc_after, e_npc);
      pc_m = e_npc;
    end

    // R1: masked pending line is ignored, a fetch happens.
    run_step(4'b1000, 4'b0111, 1'b1, 1'b0, 32'h0000_0013, 0);
    check(!o_irq && fetches == 1, "R1 masked line ignored", 64'(fetches), 64'd1);
    check(o_npc == pc_m + 64'd4, "R6 advance after mask", o_npc, pc_m + 64'd4);
    pc_m = pc_m + 64'd4;

    // R2: compressed step leaves pc 2-aligned, then a stalled fetch at that pc.
    run_step(4'b0000, 4'hF, 1'b1, 1'b0, 32'h0000_0001, 0);
    pc_m = pc_m + 64'd2;
    check(pc_after == pc_m, "R6 compressed advance", pc_after, pc_m);
    run_step(4'b0000, 4'hF, 1'b1, 1'b0, 32'h0000_0073, 3);
    check(hold_ok, "R2 request held during stall", {63'd0, hold_ok}, 64'd1);
    check(f_addr == pc_m, "R2 unaligned fetch address", f_addr, pc_m);
    check(o_npc == pc_m + 64'd4, "R6 advance after stall", o_npc, pc_m + 64'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule